// File: doc/BRIEF.md
# Effective Address and Branch Target Unit

This unit sits beside the decoder of an 8-bit microcontroller core and turns one decoded instruction into addresses. From a mode code, the one or two operand bytes, the instruction length, the current program counter, the accumulator, the two data-pointer bytes and the two indirect pointer registers of the active bank, it produces three things. The first is a memory address tagged with the bus it belongs to: program store, on-chip data or off-chip data. The second is the program counter of the next instruction, with a flag that marks a taken jump or call. The third is a new 16-bit data-pointer value, when the instruction loads it.

The program counter that enters the unit is the address of the current instruction. All PC-based forms work from the address of the following instruction, which is that PC plus the instruction length. Every sum wraps modulo 2^ADDR_W. Results are presented one clock after the request when the output register is enabled. With `OUT_REG = 0` they are presented in the same cycle.

Top module: `eau_top`

## Requirements
- R1: While reset is held and after it is released with no request, `out_valid`, `pc_load` and `dptr_load` are 0, `ea_space` is 0 (none) and `ea_addr` is 0.
- R2: With the output register on, `out_valid` is `in_valid` delayed by one clock. For mode 0 (sequential), `pc_nxt` = `pc` + `ilen` modulo 65536, `pc_load` = 0 and `ea_space` = 0.
- R3: Mode 1 (short relative): `pc_nxt` = `pc` + `ilen` + `opnd_lo` sign-extended, modulo 65536, with `pc_load` = 1.
- R4: Mode 2 (absolute): `pc_nxt` = {`opnd_hi`, `opnd_lo`} with `pc_load` = 1.
- R5: Mode 3 (in-page call): `pc_nxt` keeps bits 15:11 of `pc` + `ilen`, then takes `opnd_hi`[2:0] as bits 10:8 and `opnd_lo` as bits 7:0. `pc_load` = 1.
- R6: Mode 4 (table read through the pointer): `ea_addr` = `acc` unsigned + {`dph`,`dpl`} modulo 65536, with `ea_space` = 1 (code).
- R7: Mode 5 (table read relative to the PC): `ea_addr` = `acc` unsigned + (`pc` + `ilen`) modulo 65536, with `ea_space` = 1. In this mode `pc_nxt` is still `pc` + `ilen` and `pc_load` = 0.
- R8: Mode 6 sets `ea_addr` = {`dph`,`dpl`}. Mode 7 sets `ea_addr` = the zero-extended `r0` when `ri_sel` = 0 and the zero-extended `r1` when `ri_sel` = 1. Both modes give `ea_space` = 3 (external data).
- R9: Mode 8 sets `ea_addr` = the zero-extended `opnd_lo`. Mode 9 sets `ea_addr` = the zero-extended `r0` or `r1`, chosen by `ri_sel`. Both modes give `ea_space` = 2 (internal data), so the upper address byte is always 0.
- R10: Mode 10 (pointer load) sets `dptr_load` = 1 and `dptr_val` = {`opnd_hi`,`opnd_lo`}, with `pc_load` = 0 and `ea_space` = 0. In every other mode `dptr_load` = 0.
- R11: Mode codes 11 to 15 act as mode 0: no load, `ea_space` = 0, and `pc_nxt` = `pc` + `ilen`.
- R12: `pc_load` is 1 only for modes 1, 2 and 3. In those modes `ea_space` = 0 and `ea_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| ilen | input | 2 | Instruction length in bytes (1 to 3) |
| opnd_hi | input | DATA_W | First operand byte (high address byte / page bits) |
| opnd_lo | input | DATA_W | Second operand byte (low byte / offset / direct address) |
| pc | input | ADDR_W | Address of the current instruction |
| acc | input | DATA_W | Accumulator |
| dph | input | DATA_W | Data pointer high byte |
| dpl | input | DATA_W | Data pointer low byte |
| r0 | input | DATA_W | Pointer register 0 of the active bank |
| r1 | input | DATA_W | Pointer register 1 of the active bank |
| ri_sel | input | 1 | Selects r1 (1) or r0 (0) for indirect modes |
| out_valid | output | 1 | Result present |
| ea_addr | output | ADDR_W | Effective memory address |
| ea_space | output | 2 | 0 none, 1 code, 2 internal data, 3 external data |
| pc_load | output | 1 | Taken jump or call |
| pc_nxt | output | ADDR_W | Program counter of the next instruction |
| dptr_load | output | 1 | Data pointer is to be written |
| dptr_val | output | ADDR_W | New data pointer value |

## Verification
The bench builds the unit with its default parameters: ADDR_W = 16, DATA_W = 8, PAGE_W = 11 and the output register on. With these values the modulo-65536 wrap of relative targets and indexed reads can be reached directly, in both the forward and the backward direction. The same holds for an in-page call whose following-instruction address has crossed into a new 2 KB page. The one-cycle output latency is also exercised, so request and result can be related edge by edge.

// File: rtl/eau_pkg.sv
package eau_pkg;
   typedef enum logic [3:0] {
      M_SEQ       = 4'd0,
      M_REL       = 4'd1,
      M_ABS       = 4'd2,
      M_PAGE      = 4'd3,
      M_CODE_DPTR = 4'd4,
      M_CODE_PC   = 4'd5,
      M_XD_DPTR   = 4'd6,
      M_XD_RI     = 4'd7,
      M_ID_DIR    = 4'd8,
      M_ID_RI     = 4'd9,
      M_DPTR_IMM  = 4'd10
   } eau_mode_e;

   typedef enum logic [1:0] {
      SP_NONE  = 2'd0,
      SP_CODE  = 2'd1,
      SP_IDATA = 2'd2,
      SP_XDATA = 2'd3
   } eau_space_e;
endpackage

// File: rtl/eau_pc_calc.sv
module eau_pc_calc #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 11
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [1:0]        ilen,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] opnd_lo,
   output logic [ADDR_W-1:0] pc_seq,
   output logic [ADDR_W-1:0] pc_rel,
   output logic [ADDR_W-1:0] pc_abs,
   output logic [ADDR_W-1:0] pc_page
);
   localparam int HI_BITS = PAGE_W - DATA_W;
   localparam int EXT_W   = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] len_ext;
   logic [ADDR_W-1:0] off_ext;

   assign len_ext = {{(ADDR_W-2){1'b0}}, ilen};
   assign off_ext = {{EXT_W{opnd_lo[DATA_W-1]}}, opnd_lo};

   assign pc_seq  = pc + len_ext;
   assign pc_rel  = pc_seq + off_ext;
   assign pc_abs  = {opnd_hi, opnd_lo};
   assign pc_page = {pc_seq[ADDR_W-1:PAGE_W], opnd_hi[HI_BITS-1:0], opnd_lo};
endmodule

// File: rtl/eau_index_add.sv
module eau_index_add #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DATA_W-1:0] idx,
   output logic [ADDR_W-1:0] sum
);
   localparam int PAD_W = ADDR_W - DATA_W;

   assign sum = base + {{PAD_W{1'b0}}, idx};
endmodule

// File: rtl/eau_route.sv
module eau_route
   import eau_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [ADDR_W-1:0] dptr,
   input  logic [DATA_W-1:0] ri_val,
   input  logic [ADDR_W-1:0] pc_seq,
   input  logic [ADDR_W-1:0] pc_rel,
   input  logic [ADDR_W-1:0] pc_abs,
   input  logic [ADDR_W-1:0] pc_page,
   input  logic [ADDR_W-1:0] sum_dptr,
   input  logic [ADDR_W-1:0] sum_pc,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        space,
   output logic              jump,
   output logic [ADDR_W-1:0] next_pc,
   output logic              dp_wr,
   output logic [ADDR_W-1:0] dp_val
);
   localparam int PAD_W = ADDR_W - DATA_W;

   always_comb begin
      addr    = '0;
      space   = SP_NONE;
      jump    = 1'b0;
      next_pc = pc_seq;
      dp_wr   = 1'b0;
      dp_val  = '0;
      case (mode)
         M_REL:  begin jump = 1'b1; next_pc = pc_rel;  end
         M_ABS:  begin jump = 1'b1; next_pc = pc_abs;  end
         M_PAGE: begin jump = 1'b1; next_pc = pc_page; end
         M_CODE_DPTR: begin addr = sum_dptr; space = SP_CODE; end
         M_CODE_PC:   begin addr = sum_pc;   space = SP_CODE; end
         M_XD_DPTR:   begin addr = dptr;     space = SP_XDATA; end
         M_XD_RI:     begin addr = {{PAD_W{1'b0}}, ri_val};  space = SP_XDATA; end
         M_ID_DIR:    begin addr = {{PAD_W{1'b0}}, opnd_lo}; space = SP_IDATA; end
         M_ID_RI:     begin addr = {{PAD_W{1'b0}}, ri_val};  space = SP_IDATA; end
         M_DPTR_IMM:  begin dp_wr = 1'b1; dp_val = {opnd_hi, opnd_lo}; end
         default: ;
      endcase
   end
endmodule

// File: rtl/eau_top.sv
module eau_top #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int PAGE_W  = 11,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        mode,
   input  logic [1:0]        ilen,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] dph,
   input  logic [DATA_W-1:0] dpl,
   input  logic [DATA_W-1:0] r0,
   input  logic [DATA_W-1:0] r1,
   input  logic              ri_sel,
   output logic              out_valid,
   output logic [ADDR_W-1:0] ea_addr,
   output logic [1:0]        ea_space,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_nxt,
   output logic              dptr_load,
   output logic [ADDR_W-1:0] dptr_val
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("eau_top: ADDR_W must be twice DATA_W");
      end
      if (PAGE_W <= DATA_W || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("eau_top: PAGE_W must lie between DATA_W and ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] dptr;
   logic [DATA_W-1:0] ri_val;
   logic [ADDR_W-1:0] pc_seq, pc_rel, pc_abs, pc_page;
   logic [ADDR_W-1:0] sum_dptr, sum_pc;
   logic [ADDR_W-1:0] c_addr, c_next, c_dpv;
   logic [1:0]        c_space;
   logic              c_jump, c_dpwr;

   assign dptr   = {dph, dpl};
   assign ri_val = ri_sel ? r1 : r0;

   eau_pc_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_pc (
      .pc(pc), .ilen(ilen), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
      .pc_seq(pc_seq), .pc_rel(pc_rel), .pc_abs(pc_abs), .pc_page(pc_page)
   );

   eau_index_add #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idx_dptr (
      .base(dptr), .idx(acc), .sum(sum_dptr)
   );

   eau_index_add #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idx_pc (
      .base(pc_seq), .idx(acc), .sum(sum_pc)
   );

   eau_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
      .mode(mode), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .dptr(dptr),
      .ri_val(ri_val), .pc_seq(pc_seq), .pc_rel(pc_rel), .pc_abs(pc_abs),
      .pc_page(pc_page), .sum_dptr(sum_dptr), .sum_pc(sum_pc),
      .addr(c_addr), .space(c_space), .jump(c_jump), .next_pc(c_next),
      .dp_wr(c_dpwr), .dp_val(c_dpv)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               ea_addr   <= '0;
               ea_space  <= '0;
               pc_load   <= 1'b0;
               pc_nxt    <= '0;
               dptr_load <= 1'b0;
               dptr_val  <= '0;
            end else if (in_valid) begin
               out_valid <= 1'b1;
               ea_addr   <= c_addr;
               ea_space  <= c_space;
               pc_load   <= c_jump;
               pc_nxt    <= c_next;
               dptr_load <= c_dpwr;
               dptr_val  <= c_dpv;
            end else begin
               out_valid <= 1'b0;
               ea_addr   <= '0;
               ea_space  <= '0;
               pc_load   <= 1'b0;
               dptr_load <= 1'b0;
               dptr_val  <= '0;
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid & rst_n;
         assign ea_addr   = out_valid ? c_addr  : '0;
         assign ea_space  = out_valid ? c_space : '0;
         assign pc_load   = out_valid & c_jump;
         assign pc_nxt    = c_next;
         assign dptr_load = out_valid & c_dpwr;
         assign dptr_val  = out_valid ? c_dpv : '0;
      end
   endgenerate
endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        mode,
   input logic [DATA_W-1:0] opnd_hi,
   input logic [DATA_W-1:0] opnd_lo,
   input logic              out_valid,
   input logic [ADDR_W-1:0] ea_addr,
   input logic [1:0]        ea_space,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_nxt,
   input logic              dptr_load
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!pc_load && !dptr_load && ea_space == 2'd0)); // R1
   AST_BRANCH_NO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (ea_space == 2'd0 && ea_addr == '0)); // R12
   AST_IDATA_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_space == 2'd2) |-> (ea_addr[ADDR_W-1:DATA_W] == '0)); // R9
   AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      dptr_load |-> (!pc_load && ea_space == 2'd0)); // R10

   generate
      if (OUT_REG) begin : g_seq
         AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R2
         AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R2
         AST_ABS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 4'd2) |=> (pc_load && pc_nxt == {$past(opnd_hi), $past(opnd_lo)})); // R4
      end
   endgenerate
endmodule

bind eau_top eau_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
   .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .out_valid(out_valid),
   .ea_addr(ea_addr), .ea_space(ea_space), .pc_load(pc_load),
   .pc_nxt(pc_nxt), .dptr_load(dptr_load)
);

// File: tb/tb_eau_top.sv
`timescale 1ns/1ps
module tb_eau_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  mode = '0;
   logic [1:0]  ilen = 2'd1;
   logic [7:0]  opnd_hi = '0, opnd_lo = '0, acc = '0, dph = '0, dpl = '0, r0 = '0, r1 = '0;
   logic [15:0] pc = '0;
   logic        ri_sel = 1'b0;
   logic        out_valid, pc_load, dptr_load;
   logic [15:0] ea_addr, pc_nxt, dptr_val;
   logic [1:0]  ea_space;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   eau_top dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .ilen(ilen),
      .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .pc(pc), .acc(acc), .dph(dph), .dpl(dpl),
      .r0(r0), .r1(r1), .ri_sel(ri_sel), .out_valid(out_valid), .ea_addr(ea_addr),
      .ea_space(ea_space), .pc_load(pc_load), .pc_nxt(pc_nxt),
      .dptr_load(dptr_load), .dptr_val(dptr_val)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] m, input logic [1:0] l, input logic [7:0] hi, input logic [7:0] lo,
                        input logic [15:0] p);
      mode = m; ilen = l; opnd_hi = hi; opnd_lo = lo; pc = p; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "valid in reset", {31'd0, out_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "valid", {31'd0, out_valid}, 0);
      chk("R1", "loads", {30'd0, pc_load, dptr_load}, 0);
      chk("R1", "space", {30'd0, ea_space}, 0);
      chk("R1", "addr", {16'd0, ea_addr}, 0);
   endtask

   task automatic t_seq;
      issue(4'd0, 2'd3, 8'h00, 8'h00, 16'h1234);
      chk("R2", "valid after one clock", {31'd0, out_valid}, 1);
      chk("R2", "seq pc", {16'd0, pc_nxt}, 32'h1237);
      chk("R2", "seq no load", {31'd0, pc_load}, 0);
      issue(4'd0, 2'd2, 8'h00, 8'h00, 16'hFFFF);
      chk("R2", "seq wrap", {16'd0, pc_nxt}, 32'h0001);
      @(negedge clk);
      chk("R2", "valid drops", {31'd0, out_valid}, 0);
   endtask

   task automatic t_rel;
      issue(4'd1, 2'd2, 8'h00, 8'h10, 16'h0100);
      chk("R3", "rel forward", {16'd0, pc_nxt}, 32'h0112);
      chk("R3", "rel load", {31'd0, pc_load}, 1);
      issue(4'd1, 2'd2, 8'h00, 8'hFE, 16'h0100);
      chk("R3", "rel back self", {16'd0, pc_nxt}, 32'h0100);
      issue(4'd1, 2'd2, 8'h00, 8'h80, 16'h0010);
      chk("R3", "rel wrap low", {16'd0, pc_nxt}, 32'hFF92);
      issue(4'd1, 2'd3, 8'h00, 8'h7F, 16'hFFF0);
      chk("R3", "rel wrap high", {16'd0, pc_nxt}, 32'h0072);
      chk("R12", "rel space", {30'd0, ea_space}, 0);
   endtask

   task automatic t_abs;
      issue(4'd2, 2'd3, 8'hBE, 8'hEF, 16'h0042);
      chk("R4", "abs target", {16'd0, pc_nxt}, 32'hBEEF);
      chk("R4", "abs load", {31'd0, pc_load}, 1);
      chk("R12", "abs addr", {16'd0, ea_addr}, 0);
   endtask

   task automatic t_page;
      issue(4'd3, 2'd2, 8'hFD, 8'h34, 16'h1000);
      chk("R5", "page keep", {16'd0, pc_nxt}, 32'h1534);
      issue(4'd3, 2'd2, 8'h00, 8'h00, 16'h37FE);
      chk("R5", "page cross", {16'd0, pc_nxt}, 32'h3800);
      chk("R5", "page load", {31'd0, pc_load}, 1);
   endtask

   task automatic t_code;
      acc = 8'hFF; dph = 8'h12; dpl = 8'h34;
      issue(4'd4, 2'd1, 8'h00, 8'h00, 16'h0000);
      chk("R6", "A+DPTR", {16'd0, ea_addr}, 32'h1333);
      chk("R6", "code space", {30'd0, ea_space}, 1);
      dph = 8'hFF; dpl = 8'hF0; acc = 8'h20;
      issue(4'd4, 2'd1, 8'h00, 8'h00, 16'h0000);
      chk("R6", "A+DPTR wrap", {16'd0, ea_addr}, 32'h0010);
      acc = 8'h80;
      issue(4'd5, 2'd1, 8'h00, 8'h00, 16'h2000);
      chk("R7", "A+PC", {16'd0, ea_addr}, 32'h2081);
      chk("R7", "A+PC pc", {16'd0, pc_nxt}, 32'h2001);
      chk("R7", "A+PC no load", {31'd0, pc_load}, 0);
      acc = 8'hFF;
      issue(4'd5, 2'd1, 8'h00, 8'h00, 16'hFFFE);
      chk("R7", "A+PC wrap", {16'd0, ea_addr}, 32'h00FE);
   endtask

   task automatic t_data;
      dph = 8'hA5; dpl = 8'h5A; r0 = 8'h11; r1 = 8'hE2;
      issue(4'd6, 2'd1, 8'h00, 8'h00, 16'h0000);
      chk("R8", "xdata dptr", {16'd0, ea_addr}, 32'hA55A);
      chk("R8", "xdata space", {30'd0, ea_space}, 3);
      ri_sel = 1'b0;
      issue(4'd7, 2'd1, 8'h00, 8'h00, 16'h0000);
      chk("R8", "xdata r0", {16'd0, ea_addr}, 32'h0011);
      ri_sel = 1'b1;
      issue(4'd7, 2'd1, 8'h00, 8'h00, 16'h0000);
      chk("R8", "xdata r1", {16'd0, ea_addr}, 32'h00E2);
      issue(4'd9, 2'd1, 8'h00, 8'h00, 16'h0000);
      chk("R9", "idata r1", {16'd0, ea_addr}, 32'h00E2);
      chk("R9", "idata space", {30'd0, ea_space}, 2);
      ri_sel = 1'b0;
      issue(4'd8, 2'd2, 8'hCC, 8'h90, 16'h0000);
      chk("R9", "idata direct", {16'd0, ea_addr}, 32'h0090);
   endtask

   task automatic t_dptr;
      issue(4'd10, 2'd3, 8'h87, 8'h65, 16'h0300);
      chk("R10", "dptr load", {31'd0, dptr_load}, 1);
      chk("R10", "dptr value", {16'd0, dptr_val}, 32'h8765);
      chk("R10", "no jump", {31'd0, pc_load}, 0);
      chk("R10", "no space", {30'd0, ea_space}, 0);
      issue(4'd2, 2'd3, 8'h87, 8'h65, 16'h0300);
      chk("R10", "no dptr load in abs", {31'd0, dptr_load}, 0);
   endtask

   task automatic t_unused;
      for (int m = 11; m < 16; m++) begin
         issue(4'(m), 2'd2, 8'hFF, 8'hFF, 16'h4000);
         chk("R11", "unused pc", {16'd0, pc_nxt}, 32'h4002);
         chk("R11", "unused loads", {30'd0, pc_load, dptr_load}, 0);
         chk("R11", "unused space", {30'd0, ea_space}, 0);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_seq();
      t_rel();
      t_abs();
      t_page();
      t_code();
      t_data();
      t_dptr();
      t_unused();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule